// File: doc/BRIEF.md
# Three-Level Address Translation Table Walker

This block turns a 32-bit logical address into a physical address by walking translation tables held in ordinary memory. A request carries the address and a read/write flag. The walker fetches one 4-byte descriptor per level through a single-outstanding memory port that uses a request/acknowledge handshake. It ends with a one-cycle completion pulse. The pulse carries the physical address, a cache-inhibit attribute and a fault flag.

The walk has up to three levels. Each level uses a 4-bit slice of the address to pick one of 16 descriptors in a 64-byte table. A descriptor can end the walk at any level and map a whole 256 MB, 16 MB or 1 MB region in one step. It can also point to a table at the next level. Different entries may point at the same lower table, so the tables do not have to form a strict tree.

The walker keeps the status bits in the descriptors current. It writes back every visited descriptor whose used bit is clear, and it marks the final page descriptor as modified when the access is a write. When translation is disabled, each request completes at once with the address unchanged.

Top module: `xlat_walker`

## Requirements
- R1: After reset `busy`, `done` and `mem_req` are all low.
- R2: With `xlat_en` low, an idle request completes with `done` one cycle after `req_valid` is sampled. It returns `done_paddr` equal to the request address, with `done_ci` and `done_fault` low, and it makes no memory access.
- R3: The level-A, level-B and level-C indexes come from address bits 31:28, 27:24 and 23:20. Each descriptor is read at table base + 4 × index. The level-A base is `root_base`.
- R4: Descriptor bits 1:0 give the type. 01 is a page descriptor that ends the walk. 10 points to a next-level table whose base is the descriptor with bits 3:0 cleared.
- R5: A page descriptor found at level A, B or C keeps the low 28, 24 or 20 address bits. The physical address is the descriptor bits above that span followed by those untranslated address bits.
- R6: Any of the following ends the walk with `done_fault` high, `done_paddr` 0 and `done_ci` low, and the faulting descriptor is not written: a descriptor of type 00 or 11, or a type-10 descriptor at level C.
- R7: Bit 3 is the used flag and bit 4 the modified flag. Every visited, non-faulting descriptor with bit 3 clear is written back with bit 3 set. On a write request the final page descriptor is written with bit 4 set as well. A descriptor that needs no change is not written.
- R8: `done_ci` equals bit 6 of the page descriptor that ended the walk.
- R9: Two entries that point at the same lower table both translate through it and reach the same physical pages.
- R10: `busy` is high from the cycle after a request is accepted until completion. `done` is a one-cycle pulse during which `busy` is already low.
- R11: Once raised, `mem_req` stays high, with `mem_addr`, `mem_we` and `mem_wdata` unchanged, until the cycle in which `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xlat_en | input | 1 | Translation enable; when low, addresses pass through |
| root_base | input | 32 | Base address of the level-A table |
| req_valid | input | 1 | Translation request, taken when idle |
| req_addr | input | 32 | Logical address |
| req_write | input | 1 | 1 for a write access |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle completion pulse |
| done_paddr | output | 32 | Physical address |
| done_ci | output | 1 | Cache-inhibit attribute |
| done_fault | output | 1 | Invalid-descriptor fault |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a descriptor write-back |
| mem_addr | output | 32 | Descriptor address |
| mem_wdata | output | 32 | Descriptor value written back |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Descriptor read data |

## Verification
The bench uses the default geometry: three levels of 4-bit indexes, which gives 16-entry tables and spans of 28, 24 and 20 bits. With these values every level fits in a 64-byte table inside a 4 KB memory model. A full walk therefore comes within reach: early termination at each level, a shared level-C table reached from both the lowest and the highest 16 MB slot, and faults at every level. Memory latency varies at random from one to three cycles, so handshake stalls occur during both reads and write-backs.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int AW         = 32;
    localparam int DESC_SHIFT = 2;
    localparam int USED_BIT   = 3;
    localparam int MOD_BIT    = 4;
    localparam int CI_BIT     = 6;
    localparam int FLAG_LSBS  = 4;

    localparam logic [1:0] DT_PAGE  = 2'b01;
    localparam logic [1:0] DT_TABLE = 2'b10;

    typedef enum logic [1:0] {DK_FAULT, DK_PAGE, DK_TABLE} dkind_e;
    typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WBACK} wstate_e;

    typedef struct packed {
        dkind_e          kind;
        logic            wb;
        logic            ci;
        logic [AW-1:0]   upd;
        logic [AW-1:0]   next_base;
        logic [AW-1:0]   pa;
    } dres_t;

    function automatic int lvl_span(input int lvl, input int idx_w);
        return AW - idx_w * (lvl + 1);
    endfunction

    function automatic logic [AW-1:0] low_mask(input int span);
        return ~({AW{1'b1}} << span);
    endfunction
endpackage

// File: rtl/xlat_addr_gen.sv
module xlat_addr_gen
    import xlat_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int LVL_W = 2
) (
    input  logic [AW-1:0]    base,
    input  logic [AW-1:0]    vaddr,
    input  logic [LVL_W-1:0] lvl,
    output logic [AW-1:0]    daddr
);
    localparam logic [AW-1:0] IDX_MASK = low_mask(IDX_W);

    logic [AW-1:0] idx;

    always_comb begin
        idx   = (vaddr >> lvl_span(int'(lvl), IDX_W)) & IDX_MASK;
        daddr = base + (idx << DESC_SHIFT);
    end
endmodule

// File: rtl/xlat_desc_decode.sv
module xlat_desc_decode
    import xlat_pkg::*;
#(
    parameter int IDX_W   = 4,
    parameter int NUM_LVL = 3,
    parameter int LVL_W   = 2
) (
    input  logic [AW-1:0]    desc,
    input  logic [AW-1:0]    vaddr,
    input  logic [LVL_W-1:0] lvl,
    input  logic             wr,
    output dres_t            res
);
    localparam logic [AW-1:0] FLAG_MASK = low_mask(FLAG_LSBS);

    logic [AW-1:0] span_mask;
    logic          last_lvl;

    always_comb begin
        span_mask = low_mask(lvl_span(int'(lvl), IDX_W));
        last_lvl  = (int'(lvl) >= NUM_LVL - 1);
        res       = '0;
        res.kind  = DK_FAULT;
        res.upd   = desc;
        case (desc[1:0])
            DT_PAGE: begin
                res.kind = DK_PAGE;
                res.upd  = desc | (AW'(1) << USED_BIT) | (wr ? (AW'(1) << MOD_BIT) : '0);
                res.pa   = (desc & ~span_mask) | (vaddr & span_mask);
                res.ci   = desc[CI_BIT];
            end
            DT_TABLE: begin
                if (!last_lvl) begin
                    res.kind      = DK_TABLE;
                    res.upd       = desc | (AW'(1) << USED_BIT);
                    res.next_base = desc & ~FLAG_MASK;
                end
            end
            default: res.kind = DK_FAULT;
        endcase
        res.wb = (res.kind != DK_FAULT) && (res.upd != desc);
    end
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
    import xlat_pkg::*;
#(
    parameter int IDX_W   = 4,
    parameter int NUM_LVL = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          xlat_en,
    input  logic [AW-1:0] root_base,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic          req_write,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] done_paddr,
    output logic          done_ci,
    output logic          done_fault,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [AW-1:0] mem_rdata
);
    localparam int LVL_W = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1;

    wstate_e          st;
    logic [LVL_W-1:0] lvl;
    logic [AW-1:0]    base_q;
    logic [AW-1:0]    va_q;
    logic             wr_q;
    logic [AW-1:0]    upd_q;
    logic [AW-1:0]    next_q;
    logic [AW-1:0]    pa_q;
    logic             ci_q;
    logic             page_q;
    dres_t            dres;

    xlat_addr_gen #(.IDX_W(IDX_W), .LVL_W(LVL_W)) u_agen (
        .base  (base_q),
        .vaddr (va_q),
        .lvl   (lvl),
        .daddr (mem_addr)
    );

    xlat_desc_decode #(.IDX_W(IDX_W), .NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_dec (
        .desc  (mem_rdata),
        .vaddr (va_q),
        .lvl   (lvl),
        .wr    (wr_q),
        .res   (dres)
    );

    assign busy      = (st != ST_IDLE);
    assign mem_req   = (st != ST_IDLE);
    assign mem_we    = (st == ST_WBACK);
    assign mem_wdata = upd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            lvl        <= '0;
            base_q     <= '0;
            va_q       <= '0;
            wr_q       <= 1'b0;
            upd_q      <= '0;
            next_q     <= '0;
            pa_q       <= '0;
            ci_q       <= 1'b0;
            page_q     <= 1'b0;
            done       <= 1'b0;
            done_paddr <= '0;
            done_ci    <= 1'b0;
            done_fault <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (!xlat_en) begin
                            done       <= 1'b1;
                            done_paddr <= req_addr;
                            done_ci    <= 1'b0;
                            done_fault <= 1'b0;
                        end else begin
                            va_q   <= req_addr;
                            wr_q   <= req_write;
                            base_q <= root_base;
                            lvl    <= '0;
                            st     <= ST_READ;
                        end
                    end
                end
                ST_READ: begin
                    if (mem_ack) begin
                        upd_q  <= dres.upd;
                        next_q <= dres.next_base;
                        pa_q   <= dres.pa;
                        ci_q   <= dres.ci;
                        page_q <= (dres.kind == DK_PAGE);
                        case (dres.kind)
                            DK_PAGE: begin
                                if (dres.wb) begin
                                    st <= ST_WBACK;
                                end else begin
                                    st         <= ST_IDLE;
                                    done       <= 1'b1;
                                    done_paddr <= dres.pa;
                                    done_ci    <= dres.ci;
                                    done_fault <= 1'b0;
                                end
                            end
                            DK_TABLE: begin
                                if (dres.wb) begin
                                    st <= ST_WBACK;
                                end else begin
                                    base_q <= dres.next_base;
                                    lvl    <= lvl + LVL_W'(1);
                                end
                            end
                            default: begin
                                st         <= ST_IDLE;
                                done       <= 1'b1;
                                done_paddr <= '0;
                                done_ci    <= 1'b0;
                                done_fault <= 1'b1;
                            end
                        endcase
                    end
                end
                ST_WBACK: begin
                    if (mem_ack) begin
                        if (page_q) begin
                            st         <= ST_IDLE;
                            done       <= 1'b1;
                            done_paddr <= pa_q;
                            done_ci    <= ci_q;
                            done_fault <= 1'b0;
                        end else begin
                            base_q <= next_q;
                            lvl    <= lvl + LVL_W'(1);
                            st     <= ST_READ;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R11: request held stable until acknowledged
    a_r11_req_held: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R7: every write-back carries the used flag
    a_r7_wb_sets_used: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> mem_wdata[USED_BIT]);

    // R10: completion pulse never overlaps busy, and lasts one cycle
    a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !mem_req));
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2: disabled translation passes the address straight through
    a_r2_bypass: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_valid && !xlat_en) |=> (done && !done_fault && !done_ci && (done_paddr == $past(req_addr))));

    // R6: a fault reports no attribute and a zero address
    a_r6_fault_clean: assert property (@(posedge clk) disable iff (rst)
        (done && done_fault) |-> (!done_ci && done_paddr == '0));
endmodule

// File: tb/tb_xlat_walker.sv
module tb_xlat_walker;
    logic        clk = 1'b0;
    logic        rst;
    logic        xlat_en;
    logic [31:0] root_base;
    logic        req_valid;
    logic [31:0] req_addr;
    logic        req_write;
    logic        busy, done, done_ci, done_fault;
    logic [31:0] done_paddr;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    logic [31:0] mem  [1024];
    logic [31:0] emem [1024];
    int          lat;
    int          wait_cnt;
    int          wr_cnt;
    int          req_cyc;
    int          checks;
    int          failures;
    bit          finished;

    always #4 clk = ~clk;

    xlat_walker dut (
        .clk(clk), .rst(rst), .xlat_en(xlat_en), .root_base(root_base),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .busy(busy), .done(done), .done_paddr(done_paddr), .done_ci(done_ci),
        .done_fault(done_fault), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata)
    );

    // memory responder with random latency
    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (rst) begin
            wait_cnt <= 0;
        end else if (mem_req && !mem_ack) begin
            req_cyc <= req_cyc + 1;
            if (wait_cnt >= lat) begin
                mem_ack  <= 1'b1;
                wait_cnt <= 0;
                lat      <= int'($urandom % 3);
                if (mem_we) begin
                    mem[mem_addr[11:2]] <= mem_wdata;
                    wr_cnt <= wr_cnt + 1;
                end else begin
                    mem_rdata <= mem[mem_addr[11:2]];
                end
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic setd(input logic [31:0] a, input logic [31:0] v);
        mem[a[11:2]]  = v;
        emem[a[11:2]] = v;
    endtask

    // independent model of the walk on the expected memory image
    task automatic ref_walk(input logic [31:0] va, input bit wr, output logic [31:0] pa,
                            output bit ci, output bit flt, output int nwr);
        logic [31:0] base, a, d, nd, m;
        int span;
        base = root_base; pa = 0; ci = 0; flt = 1; nwr = 0;
        for (int l = 0; l < 3; l++) begin
            span = 28 - 4 * l;
            a = base + (((va >> span) & 32'hF) << 2);
            d = emem[a[11:2]];
            m = ~(32'hFFFF_FFFF << span);
            if (d[1:0] == 2'b01) begin
                nd = d | 32'h8 | (wr ? 32'h10 : 32'h0);
                if (nd != d) nwr++;
                emem[a[11:2]] = nd;
                pa = (d & ~m) | (va & m); ci = d[6]; flt = 0;
                return;
            end else if (d[1:0] == 2'b10 && l < 2) begin
                nd = d | 32'h8;
                if (nd != d) nwr++;
                emem[a[11:2]] = nd;
                base = d & ~32'hF;
            end else begin
                return;
            end
        end
    endtask

    task automatic xlat(input logic [31:0] va, input bit wr, input string tag);
        logic [31:0] epa;
        bit eci, eflt;
        int ewr, n, w0, r0, bad;
        if (xlat_en) ref_walk(va, wr, epa, eci, eflt, ewr);
        else begin epa = va; eci = 0; eflt = 0; ewr = 0; end
        w0 = wr_cnt; r0 = req_cyc;
        @(negedge clk);
        req_valid = 1'b1; req_addr = va; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        if (xlat_en) chk(busy == 1'b1, {"R10 busy after accept ", tag}, 32'(busy), 32'd1);
        n = 0;
        while (!done && n < 2000) begin @(negedge clk); n++; end
        if (!done) begin
            chk(1'b0, {"R10 watchdog ", tag}, 32'd0, 32'd1);
        end else begin
            chk(done_paddr == epa, {"R5 paddr ", tag}, done_paddr, epa);
            chk(done_ci == eci, {"R8 ci ", tag}, 32'(done_ci), 32'(eci));
            chk(done_fault == eflt, {"R6 fault ", tag}, 32'(done_fault), 32'(eflt));
            chk(busy == 1'b0, {"R10 busy at done ", tag}, 32'(busy), 32'd0);
            chk((wr_cnt - w0) == ewr, {"R7 writebacks ", tag}, 32'(wr_cnt - w0), 32'(ewr));
            bad = 0;
            for (int i = 0; i < 1024; i++) if (mem[i] !== emem[i]) bad++;
            chk(bad == 0, {"R7 descriptor image ", tag}, 32'(bad), 32'd0);
            if (!xlat_en) chk(req_cyc == r0, {"R2 no memory access ", tag}, 32'(req_cyc - r0), 32'd0);
        end
        @(negedge clk);
        chk(done == 1'b0, {"R10 pulse ", tag}, 32'(done), 32'd0);
    endtask

    initial begin
        void'($urandom(32'd20241211));
        checks = 0; failures = 0; finished = 0;
        wr_cnt = 0; req_cyc = 0; lat = 1; wait_cnt = 0;
        mem_ack = 0; mem_rdata = 0;
        rst = 1; xlat_en = 0; root_base = 32'h700;
        req_valid = 0; req_addr = 0; req_write = 0;
        for (int i = 0; i < 1024; i++) setd(32'(i * 4), 32'h0);
        // level A at 0x700
        setd(32'h700, 32'h0000_0742);
        for (int i = 1; i < 8; i++) setd(32'h700 + 32'(i * 4), (32'(i) << 28) | 32'h1);
        for (int i = 8; i < 15; i++) setd(32'h700 + 32'(i * 4), (32'(i) << 28) | 32'h41);
        setd(32'h73C, 32'h0000_0782);
        // level B tables at 0x740 and 0x780
        setd(32'h740, 32'h0000_07C2);
        for (int i = 1; i < 16; i++) setd(32'h740 + 32'(i * 4), (32'(i) << 24) | 32'h1);
        for (int i = 0; i < 15; i++) setd(32'h780 + 32'(i * 4), 32'hF000_0000 | (32'(i) << 24) | 32'h41);
        setd(32'h7BC, 32'h0000_07C2);
        // level C table at 0x7C0, shared
        for (int i = 0; i < 15; i++) setd(32'h7C0 + 32'(i * 4), (32'(i) << 20) | 32'h1);
        setd(32'h7FC, 32'h00F0_0041);

        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(busy == 0 && done == 0 && mem_req == 0, "R1 reset state", {29'd0, busy, done, mem_req}, 32'd0);

        xlat(32'hDEAD_BEEF, 1'b0, "R2 disabled passthrough");
        xlat(32'h0123_4567, 1'b1, "R2 disabled write");
        xlat_en = 1;
        xlat(32'h1234_5678, 1'b0, "R4 level-A page");
        xlat(32'h8ABC_DEF0, 1'b1, "R8 level-A CI write");
        xlat(32'h0312_3456, 1'b0, "R3 level-B page");
        xlat(32'h00D1_2345, 1'b1, "R3 level-C page write");
        xlat(32'hFF51_2345, 1'b0, "R9 shared table high");
        xlat(32'h0051_2345, 1'b0, "R9 shared table low");
        xlat(32'hFFF0_1234, 1'b0, "R8 level-C CI via shared");
        setd(32'h708, 32'h3000_0001);
        xlat(32'h2ABC_DEF0, 1'b0, "R5 remapped level-A");
        setd(32'h750, 32'h0A00_0019);
        xlat(32'h0477_0001, 1'b1, "R7 flags already set");
        setd(32'h714, 32'h0000_0000);
        xlat(32'h5000_0000, 1'b0, "R6 type 00 level A");
        setd(32'h748, 32'h0200_0003);
        xlat(32'h0200_1000, 1'b1, "R6 type 11 level B");
        setd(32'h7F8, 32'h0000_07C2);
        xlat(32'h00E0_0010, 1'b0, "R6 table at level C");

        for (int k = 0; k < 300; k++) begin
            logic [31:0] va;
            va = $urandom;
            case ($urandom % 4)
                0: va[31:28] = 4'h0;
                1: va[31:24] = 8'hFF;
                2: va[31:24] = 8'h00;
                default: ;
            endcase
            if ($urandom % 4 == 0) begin
                int w;
                w = 448 + int'($urandom % 64);
                mem[w][4:3]  = 2'b00;
                emem[w][4:3] = 2'b00;
            end
            xlat_en = ($urandom % 16) != 0;
            xlat(va, 1'($urandom % 2), "R3 random walk");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL R10 global watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule